// File: doc/BRIEF.md
# Printer Port Register Block (Compatibility Mode)

This block holds the byte-wide registers of a PC-style printer port in standard compatibility mode. It sits behind a small register bus: a 3-bit offset, read and write strobes, and 8-bit write and read data. It holds a data register, a status register and a control register. Read data is combinational and comes from the register state before the current access; every update takes effect on the clock edge of the access. When a read and a write arrive in the same cycle, only the write acts.

No printer is attached. The block runs a small handshake model inside itself, so the busy and acknowledge status bits respond to control-register writes and to status reads as a real printer would from the driver's point of view. When the driver raises the strobe bit, the latched output byte leaves on an output stream. Bytes sampled from the port pins arrive on an input stream, and they can be read back when the direction bit selects input. A level interrupt reports a pending acknowledge event.

Both byte interfaces are valid/ready. The input stream never applies back-pressure: `in_ready` is held at 1 and every cycle with `in_valid` high loads the input register. The output stream keeps `out_valid` and `out_byte` steady until the cycle in which `out_ready` is high. If a new byte is emitted before the old one is taken, the new byte replaces the old one and the output stays valid, because a printer port keeps no queue.

Top module: `lpt_compat_regs`

## Requirements
- R1: Only offsets 0 (data), 1 (status) and 2 (control) are decoded. A read at offsets 3 to 7 returns 0xFF. A write at those offsets changes no register.
- R2: A control write stores the written byte with bits 7 and 6 forced to 1. A read of offset 2 returns the stored value exactly. Control bits: 5 = direction (1 = input), 4 = interrupt enable, 3 = select, 2 = init, 0 = strobe.
- R3: A control write with init (bit 2) at 0 sets status to 0xD8. Status bits: 7 = busy, 6 = ack, 4 = online, 3 = error, 0 = timeout.
- R4: A control write with init, select and strobe all 1 clears status bit 7. It emits the data-write byte on the output stream only if the previously stored strobe bit was 0.
- R5: An emitted byte holds `out_valid` and `out_byte` until `out_ready` is high at a clock edge. A newer emission replaces a byte that has not yet been taken.
- R6: A control write with init and select at 1 and strobe at 0 sets the interrupt-pending flag only when the previously stored control has interrupt enable (bit 4) set.
- R7: A status read returns the status and clears the interrupt-pending flag.
- R8: After a status read with busy at 0 and stored strobe at 0, ack is cleared if it was set. Otherwise ack and busy are both set. In any other state the read leaves the status unchanged.
- R9: A data read returns the input-data register when direction is 1, and the last written data byte when direction is 0.
- R10: `in_ready` is always 1. Each cycle with `in_valid` high loads `in_byte` into the input-data register.
- R11: After reset, both data registers are 0xFF, status is 0xD9, control is 0xCC, interrupt pending is cleared and no output byte is valid.
- R12: `irq` equals the interrupt-pending flag. It rises only after a control write and falls only after a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the pre-access state |
| in_byte | input | 8 | Byte sampled from the port pins |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Always 1 |
| out_byte | output | 8 | Byte sent to the printer side |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Printer side accepts the output byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the two-step acknowledge cycle. Status reads move it only when busy is already clear and the stored strobe is low, so the stimulus must first raise strobe with interrupt enable set, which clears busy, and then drop strobe, which sets the pending flag. Only after that do three status reads in a row show the ack clear, the ack and busy set, and then no change. The stream tests hold `out_ready` low across two emissions, which shows the replacement rule. A repeated strobe-high write then shows that no byte is emitted when the stored strobe was already 1.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd2;

  // control bit positions
  localparam int CB_DIR = 5;
  localparam int CB_IEN = 4;
  localparam int CB_SEL = 3;
  localparam int CB_INI = 2;
  localparam int CB_STB = 0;

  // status bit positions
  localparam int SB_BUSY = 7;
  localparam int SB_ACK  = 6;

  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] BYTE_IDLE  = 8'hFF;
endpackage

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_next,
  output logic [BYTE_W-1:0] ctrl_q
);
  assign ctrl_next = wdata | CTRL_FORCE;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= ctrl_next;
  end

  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == ($past(wdata) | 8'hC0));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/lpt_status_hs.sv
module lpt_status_hs
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] ctrl_next,
  input  logic [BYTE_W-1:0] ctrl_q,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] status_q,
  output logic              pend_q,
  output logic              emit
);
  logic init_hi, sel_stb_hi, sel_stb_lo, hs_step;

  assign init_hi    = ctrl_next[CB_INI];
  assign sel_stb_hi = init_hi && ctrl_next[CB_SEL] && ctrl_next[CB_STB];
  assign sel_stb_lo = init_hi && ctrl_next[CB_SEL] && !ctrl_next[CB_STB];
  assign emit       = ctrl_wr && sel_stb_hi && !ctrl_q[CB_STB];
  assign hs_step    = !status_q[SB_BUSY] && !ctrl_q[CB_STB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STAT_RST;
      pend_q   <= 1'b0;
    end else if (ctrl_wr) begin
      if (!init_hi)
        status_q <= STAT_INIT;
      else if (sel_stb_hi)
        status_q[SB_BUSY] <= 1'b0;
      else if (sel_stb_lo && ctrl_q[CB_IEN])
        pend_q <= 1'b1;
    end else if (stat_rd) begin
      pend_q <= 1'b0;
      if (hs_step) begin
        if (status_q[SB_ACK]) begin
          status_q[SB_ACK] <= 1'b0;
        end else begin
          status_q[SB_ACK]  <= 1'b1;
          status_q[SB_BUSY] <= 1'b1;
        end
      end
    end
  end

  assert_init_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_next[2]) |=> status_q == 8'hD8);

  assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_next[2] && ctrl_next[3] && ctrl_next[0]) |=> !status_q[7]);

  assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !pend_q);

  assert_pend_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(ctrl_wr));

  assert_pend_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(stat_rd));
endmodule

// File: rtl/lpt_out_hold.sv
module lpt_out_hold
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  input  logic              out_ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= BYTE_IDLE;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_byte  <= byte_in;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !emit) |=> (out_valid && $stable(out_byte)));

  assert_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> (out_valid && out_byte == $past(byte_in)));

  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !emit) |=> !out_valid);
endmodule

// File: rtl/lpt_compat_regs.sv
module lpt_compat_regs
  import lpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  in_byte,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [7:0]  out_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        irq
);
  logic              wr_data, wr_ctrl, rd_stat;
  logic [BYTE_W-1:0] dout_q, din_q, ctrl_q, ctrl_next, status_q;
  logic              pend_q, emit;

  assign wr_data  = bus_wr && (bus_addr == OFF_DATA);
  assign wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
  assign rd_stat  = bus_rd && !bus_wr && (bus_addr == OFF_STAT);
  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= BYTE_IDLE;
      din_q  <= BYTE_IDLE;
    end else begin
      if (wr_data)             dout_q <= bus_wdata;
      if (in_valid && in_ready) din_q  <= in_byte;
    end
  end

  lpt_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_ctrl),
    .wdata     (bus_wdata),
    .ctrl_next (ctrl_next),
    .ctrl_q    (ctrl_q)
  );

  lpt_status_hs u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (wr_ctrl),
    .ctrl_next (ctrl_next),
    .ctrl_q    (ctrl_q),
    .stat_rd   (rd_stat),
    .status_q  (status_q),
    .pend_q    (pend_q),
    .emit      (emit)
  );

  lpt_out_hold u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (emit),
    .byte_in   (dout_q),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .out_ready (out_ready)
  );

  always_comb begin
    unique case (bus_addr)
      OFF_DATA: bus_rdata = ctrl_q[CB_DIR] ? din_q : dout_q;
      OFF_STAT: bus_rdata = status_q;
      OFF_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = BYTE_IDLE;
    endcase
  end

  assign irq = pend_q;

  assert_din_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> din_q == $past(in_byte));

  assert_dout_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(dout_q));
endmodule

// File: tb/lpt_compat_regs_bench.sv
`timescale 1ns/1ps
module lpt_compat_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] in_byte = '0;
  logic       in_valid = 1'b0, in_ready;
  logic [7:0] out_byte;
  logic       out_valid, out_ready = 1'b1, irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpt_compat_regs u_lpt_compat_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
    .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready),
    .irq(irq)
  );

  // {req[3:0], rd, addr[2:0], data[7:0], expected[7:0], irq_after}
  function automatic logic [24:0] mk(int req, bit rd, int a, int d, int e, bit q);
    return {req[3:0], rd, a[2:0], d[7:0], e[7:0], q};
  endfunction

  localparam int NV = 28;
  localparam logic [24:0] VEC [NV] = '{
    mk(11, 1, 2, 8'h00, 8'hCC, 0),  // R11 control reset
    mk(11, 1, 1, 8'h00, 8'hD9, 0),  // R11 status reset, busy set so no step
    mk(11, 1, 0, 8'h00, 8'hFF, 0),  // R11 data reset
    mk(1,  1, 5, 8'h00, 8'hFF, 0),  // R1 unused offset
    mk(1,  1, 7, 8'h00, 8'hFF, 0),  // R1 unused offset
    mk(1,  0, 0, 8'h5A, 8'h00, 0),  // R1 data write
    mk(9,  1, 0, 8'h00, 8'h5A, 0),  // R9 direction out
    mk(3,  0, 2, 8'h08, 8'h00, 0),  // R3 init low
    mk(2,  1, 2, 8'h00, 8'hC8, 0),  // R2 forced top bits
    mk(3,  1, 1, 8'h00, 8'hD8, 0),  // R3 status after init
    mk(6,  0, 2, 8'h1C, 8'h00, 0),  // R6 enable was off: no pending
    mk(8,  1, 1, 8'h00, 8'hD8, 0),  // R8 busy set: no step
    mk(4,  0, 2, 8'h1D, 8'h00, 0),  // R4 strobe high clears busy
    mk(2,  1, 2, 8'h00, 8'hDD, 0),  // R2 readback
    mk(6,  0, 2, 8'h1C, 8'h00, 1),  // R6 pending set
    mk(7,  1, 1, 8'h00, 8'h58, 0),  // R7 read clears pending
    mk(8,  1, 1, 8'h00, 8'h18, 0),  // R8 ack cleared
    mk(8,  1, 1, 8'h00, 8'hD8, 0),  // R8 ack and busy set
    mk(6,  0, 2, 8'h3C, 8'h00, 1),  // R6 pending again, dir in
    mk(9,  1, 0, 8'h00, 8'hFF, 1),  // R9 input register, irq held
    mk(7,  1, 1, 8'h00, 8'hD8, 0),  // R7 clear
    mk(1,  0, 4, 8'h00, 8'h00, 0),  // R1 ignored write
    mk(1,  0, 3, 8'h5A, 8'h00, 0),  // R1 ignored write
    mk(1,  1, 2, 8'h00, 8'hFC, 0),  // R1 control untouched
    mk(1,  1, 0, 8'h00, 8'hFF, 0),  // R1 data untouched
    mk(6,  0, 2, 8'h04, 8'h00, 0),  // R6 select low: nothing
    mk(9,  1, 0, 8'h00, 8'h5A, 0),  // R9 direction out again
    mk(8,  1, 1, 8'h00, 8'hD8, 0)   // R8 unchanged
  };

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_op(bit rd, logic [2:0] a, logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = rd; bus_wr = !rd;
    #1 r = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(out_valid == 0 && irq == 0, "R11", {out_valid, irq}, 0);
    chk(in_ready == 1, "R10", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[24:21], i);
      bus_op(v[20], v[19:17], v[16:9], r);
      if (v[20]) chk(r == v[8:1], tag, r, v[8:1]);
      chk(irq == v[0], {tag, " irq R12"}, irq, v[0]);
    end

    // R10: input stream load, then read with direction in
    @(negedge clk); in_byte = 8'hA5; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; in_byte = 8'h00;
    bus_op(0, 2, 8'h20, r);
    bus_op(1, 0, 8'h00, r);
    chk(r == 8'hA5, "R10", r, 8'hA5);

    // R4/R5: emission under back-pressure
    @(negedge clk); out_ready = 1'b0;
    bus_op(0, 0, 8'h11, r);
    bus_op(0, 2, 8'h0C, r);
    chk(out_valid == 0, "R4 no emit on strobe low", out_valid, 0);
    bus_op(0, 2, 8'h0D, r);
    chk(out_valid == 1 && out_byte == 8'h11, "R4 emit", out_byte, 8'h11);
    repeat (2) @(posedge clk);
    #1 chk(out_valid == 1 && out_byte == 8'h11, "R5 hold", out_byte, 8'h11);
    bus_op(1, 1, 8'h00, r);
    chk(r == 8'h58, "R4 busy cleared", r, 8'h58);
    bus_op(0, 2, 8'h0C, r);
    bus_op(0, 0, 8'h22, r);
    bus_op(0, 2, 8'h0D, r);
    chk(out_valid == 1 && out_byte == 8'h22, "R5 replace", out_byte, 8'h22);
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 0, "R5 drain", out_valid, 0);
    @(negedge clk); out_ready = 1'b0;
    bus_op(0, 2, 8'h0D, r);
    chk(out_valid == 0, "R4 no emit when strobe already high", out_valid, 0);

    // R11: reset mid-run
    bus_op(0, 0, 8'h33, r);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    bus_op(1, 2, 8'h00, r);
    chk(r == 8'hCC, "R11 control", r, 8'hCC);
    bus_op(1, 1, 8'h00, r);
    chk(r == 8'hD9, "R11 status", r, 8'hD9);
    bus_op(1, 0, 8'h00, r);
    chk(r == 8'hFF, "R11 data", r, 8'hFF);
    chk(out_valid == 0 && irq == 0, "R11 outputs", {out_valid, irq}, 0);

    done = 1;
    finish_run();
  end
endmodule